// File: doc/BRIEF.md
# Search-Engine Write Address Resolver

This block accepts write commands aimed at a content-addressable search device and turns each one into a stream of single-cycle write strobes. A command is qualified by a valid signal, a 2-bit opcode and a 7-bit argument field. The cycle after the command carries a 68-bit control word on the shared data bus. The data beats follow in consecutive cycles: one beat for a single write, and up to a fixed burst length for a burst.

The control word selects the target: the data array, the mask array or the external SRAM. It also selects how the 15-bit location is formed. In direct mode the location comes straight from the word. In indirect mode the upper bits come from one of eight search-result registers held inside the block, and the two lowest bits of that register are ORed with the two lowest bits of the word. The search-result registers are plain registers that are loaded through a separate port.

Each data beat produces one strobe carrying the target, the address and the data. Within a burst the address steps by one per beat and wraps at 2^15. A new command is taken only once the previous one has finished.

Top module: `sewr_resolver`

## Requirements
- R1: After reset `wr_stb`, `err_pulse` and `busy` are all 0.
- R2: A command is accepted only when `cmd_valid` is 1, `cmd_op` is 2'b01 and the block is idle. Any other opcode produces no write and no error. The control word is taken from `dq` in the cycle after acceptance.
- R3: When bit 29 of the control word is 0 (direct mode), the write address is word[14:0]. Bits 67:30, 25:21 and 18:15 have no effect on the result.
- R4: When bit 29 is 1 (indirect mode), word[28:26] selects search-result register k. The address is then {reg_k[14:2], reg_k[1] | word[1], reg_k[0] | word[0]}.
- R5: word[20:19] gives the target and appears on `wr_tgt` as 00 for the data array, 01 for the mask array and 10 for the external SRAM.
- R6: Target code 11 produces no write. `err_pulse` is high for exactly one cycle, the cycle after the control word, and the block returns to idle.
- R7: With `cmd_arg[0]` = 0 (single write), the single data beat in the cycle after the control word produces exactly one strobe, one cycle later. That strobe carries the beat's data.
- R8: With `cmd_arg[0]` = 1 (burst), up to 4 consecutive beats each produce a strobe one cycle later. Beat i has address (base + i) mod 2^15, with the same target for every beat.
- R9: In a burst, `last_beat` high on a data beat makes that beat the final one, so later cycles produce no strobe.
- R10: `cmd_valid` during the address or data phase of a command is ignored.
- R11: When `ssr_ld_en` is 1, `ssr_ld_val` is written into search-result register `ssr_ld_idx` at the clock edge. An indirect resolve in the same cycle uses the value held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command qualifier |
| cmd_op | input | 2 | Opcode, 2'b01 = write |
| cmd_arg | input | 7 | Argument field, bit 0 = burst |
| dq | input | 68 | Control word, then data beats |
| last_beat | input | 1 | End-of-transfer marker on a data beat |
| ssr_ld_en | input | 1 | Search-result register load enable |
| ssr_ld_idx | input | 3 | Register to load |
| ssr_ld_val | input | 15 | Value to load |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_tgt | output | 2 | Target of the write |
| wr_addr | output | 15 | Resolved write address |
| wr_data | output | 68 | Write data |
| err_pulse | output | 1 | Reserved-target flag, one cycle |
| busy | output | 1 | Command in progress |

## Verification
The search-result register load port and the indirect resolve can act in the same cycle. The bench provokes this by loading the register named by an indirect control word in exactly the cycle that word is on `dq`. The scoreboard expects the address built from the register's old contents, and a following indirect command to use the new value. A second overlap is a new write command presented while a burst is still moving. The check is that the strobe stream holds only the burst's own entries, and that the strobe and error counts match the model.

// File: rtl/sewr_resolver.sv
module sewr_resolver #(
  parameter int AW        = 15,
  parameter int DW        = 68,
  parameter int NSSR      = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic [6:0]              cmd_arg,
  input  logic [DW-1:0]           dq,
  input  logic                    last_beat,
  input  logic                    ssr_ld_en,
  input  logic [$clog2(NSSR)-1:0] ssr_ld_idx,
  input  logic [AW-1:0]           ssr_ld_val,
  output logic                    wr_stb,
  output logic [1:0]              wr_tgt,
  output logic [AW-1:0]           wr_addr,
  output logic [DW-1:0]           wr_data,
  output logic                    err_pulse,
  output logic                    busy
);
  localparam int IW       = $clog2(NSSR);
  localparam int BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int MODE_BIT = 29;
  localparam int IDX_LO   = 26;
  localparam int TGT_LO   = 19;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TGT_RSVD = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t             st_q;
  logic [AW-1:0]   ssr_q [NSSR];
  logic            burst_q;
  logic [BW-1:0]   beat_q;
  logic [AW-1:0]   base_q;
  logic [1:0]      tgt_q;

  logic [AW-1:0]   sel_reg;
  logic [AW-1:0]   res_addr;
  logic [1:0]      tgt_in;
  logic            final_beat;

  assign sel_reg    = ssr_q[dq[IDX_LO +: IW]];
  assign res_addr   = dq[MODE_BIT] ? {sel_reg[AW-1:2], sel_reg[1:0] | dq[1:0]} : dq[AW-1:0];
  assign tgt_in     = dq[TGT_LO +: 2];
  assign final_beat = !burst_q || last_beat || (beat_q == BW'(BURST_LEN-1));
  assign busy       = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSSR; i++) ssr_q[i] <= '0;
    end else if (ssr_ld_en) begin
      ssr_q[ssr_ld_idx] <= ssr_ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      burst_q   <= 1'b0;
      beat_q    <= '0;
      base_q    <= '0;
      tgt_q     <= '0;
      wr_stb    <= 1'b0;
      wr_tgt    <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      err_pulse <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      err_pulse <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (cmd_valid && cmd_op == OP_WRITE) begin
            st_q    <= S_ADDR;
            burst_q <= cmd_arg[0];
          end
        end
        S_ADDR: begin
          beat_q <= '0;
          base_q <= res_addr;
          tgt_q  <= tgt_in;
          if (tgt_in == TGT_RSVD) begin
            err_pulse <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            st_q <= S_DATA;
          end
        end
        S_DATA: begin
          wr_stb  <= 1'b1;
          wr_tgt  <= tgt_q;
          wr_addr <= base_q + AW'(beat_q);
          wr_data <= dq;
          beat_q  <= beat_q + 1'b1;
          if (final_beat) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sewr_resolver_chk.sv
module sewr_resolver_chk #(
  parameter int AW        = 15,
  parameter int BURST_LEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic [1:0]    wr_tgt,
  input logic [AW-1:0] wr_addr,
  input logic          err_pulse,
  input logic          busy
);
  int run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 0;
    else if (wr_stb) run_q <= run_q + 1;
    else run_q <= 0;
  end

  a_r6_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  a_r6_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !wr_stb);
  a_r2_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(busy));
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> (wr_addr == $past(wr_addr) + AW'(1)));
  a_r8_tgt_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> $stable(wr_tgt));
  a_r8_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= BURST_LEN);
  a_r5_tgt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_tgt != 2'b11));
endmodule

bind sewr_resolver sewr_resolver_chk #(.AW(AW), .BURST_LEN(BURST_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_tgt(wr_tgt),
  .wr_addr(wr_addr), .err_pulse(err_pulse), .busy(busy));

// File: tb/sewr_resolver_tb_top.sv
module sewr_resolver_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [6:0]  cmd_arg = 0;
  logic [67:0] dq = 0;
  logic        last_beat = 0;
  logic        ssr_ld_en = 0;
  logic [2:0]  ssr_ld_idx = 0;
  logic [14:0] ssr_ld_val = 0;
  logic        wr_stb, err_pulse, busy;
  logic [1:0]  wr_tgt;
  logic [14:0] wr_addr;
  logic [67:0] wr_data;

  always #2.5 clk = ~clk;

  sewr_resolver dut_i (.*);

  int checks = 0, errors = 0;
  int stb_cnt = 0, err_cnt = 0, exp_stb = 0, exp_err = 0;
  logic [14:0] ssr_m [8];
  logic [1:0]  q_tgt [$];
  logic [14:0] q_addr [$];
  logic [67:0] q_data [$];
  string       q_tag [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (err_pulse) err_cnt++;
    if (wr_stb) begin
      stb_cnt++;
      if (q_addr.size() == 0) chk(0, "R2/R10", "unexpected strobe addr", wr_addr, 0);
      else begin
        automatic logic [1:0]  et = q_tgt.pop_front();
        automatic logic [14:0] ea = q_addr.pop_front();
        automatic logic [67:0] ed = q_data.pop_front();
        automatic string       tg = q_tag.pop_front();
        chk(wr_tgt == et && wr_addr == ea && wr_data == ed, tg, "tgt/addr",
            {wr_tgt, wr_addr}, {et, ea});
      end
    end
  end

  function automatic logic [67:0] beat_val(int seed, int i);
    return {4'h9, 32'(seed * 131 + i), 32'hBEEF_0000 + 32'(i)};
  endfunction

  task automatic load_ssr(input int idx, input logic [14:0] v);
    @(negedge clk);
    ssr_ld_en = 1; ssr_ld_idx = 3'(idx); ssr_ld_val = v;
    @(negedge clk);
    ssr_ld_en = 0;
    ssr_m[idx] = v;
  endtask

  // eot_at: beat index carrying last_beat (-1 none); ld_idx >= 0 loads in address cycle
  task automatic drive(input logic [1:0] op, input bit burst, input logic [67:0] word,
                       input int nbeats, input int eot_at, input int seed,
                       input string tag, input int ld_idx, input logic [14:0] ld_val,
                       input bit poke_cmd);
    logic [14:0] base;
    logic [14:0] r;
    int nw;
    r = ssr_m[word[28:26]];
    base = word[29] ? {r[14:2], r[1:0] | word[1:0]} : word[14:0];
    nw = 0;
    if (op == 2'b01) begin
      if (word[20:19] == 2'b11) exp_err++;
      else nw = !burst ? 1 : (eot_at >= 0 ? eot_at + 1 : 4);
    end
    for (int i = 0; i < nw; i++) begin
      q_tgt.push_back(word[20:19]);
      q_addr.push_back(base + 15'(i));
      q_data.push_back(beat_val(seed, i));
      q_tag.push_back(tag);
      exp_stb++;
    end
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_arg = {6'h2A, burst};
    @(negedge clk);
    cmd_valid = poke_cmd; cmd_op = 2'b01; dq = word;
    if (ld_idx >= 0) begin
      ssr_ld_en = 1; ssr_ld_idx = 3'(ld_idx); ssr_ld_val = ld_val;
    end
    for (int i = 0; i < nbeats; i++) begin
      @(negedge clk);
      ssr_ld_en = 0;
      if (ld_idx >= 0) ssr_m[ld_idx] = ld_val;
      cmd_valid = poke_cmd;
      dq = beat_val(seed, i);
      last_beat = (i == eot_at);
    end
    @(negedge clk);
    cmd_valid = 0; last_beat = 0; dq = '0; ssr_ld_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic counts(input string tag);
    chk(stb_cnt == exp_stb, tag, "strobe count", stb_cnt, exp_stb);
    chk(err_cnt == exp_err, tag, "error count", err_cnt, exp_err);
  endtask

  function automatic logic [67:0] mk(input logic ind, input logic [2:0] idx,
                                     input logic [1:0] tgt, input logic [14:0] a,
                                     input bit junk);
    logic [67:0] w;
    w = junk ? {38'h3F_FFFF_FFFF, 1'b0, 3'b0, 5'h1F, 2'b0, 4'hF, 15'h0} : '0;
    w[29] = ind; w[28:26] = idx; w[20:19] = tgt; w[14:0] = a;
    return w;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) ssr_m[i] = '0;
    repeat (3) @(negedge clk);
    chk(wr_stb == 0, "R1", "wr_stb in reset", wr_stb, 0);
    rst_n = 1;
    @(negedge clk);
    chk(wr_stb == 0 && err_pulse == 0, "R1", "outputs after reset", {wr_stb, err_pulse}, 0);
    chk(busy == 0, "R1", "busy after reset", busy, 0);

    for (int i = 0; i < 8; i++) load_ssr(i, 15'(16'h1000 + i * 16'h0111) & 15'h7FFE);
    // R3 direct, reserved bits set, data array
    drive(2'b01, 0, mk(0, 3'd6, 2'b00, 15'h1234, 1), 1, -1, 1, "R3", -1, 0, 0);
    // R5 mask target, direct
    drive(2'b01, 0, mk(0, 3'd0, 2'b01, 15'h0F0F, 0), 1, -1, 2, "R5", -1, 0, 0);
    // R4 indirect, SRAM target, low bits ORed
    load_ssr(5, 15'h2ACA);
    drive(2'b01, 0, mk(1, 3'd5, 2'b10, 15'h0001, 1), 1, -1, 3, "R4", -1, 0, 0);
    counts("R7");
    // R8 burst with wrap
    drive(2'b01, 1, mk(0, 3'd0, 2'b00, 15'h7FFE, 0), 4, -1, 4, "R8", -1, 0, 0);
    // R8 indirect burst mask
    drive(2'b01, 1, mk(1, 3'd3, 2'b01, 15'h0003, 0), 4, -1, 5, "R8", -1, 0, 0);
    counts("R8");
    // R9 early end at beat 1, extra beats driven afterwards
    drive(2'b01, 1, mk(0, 3'd0, 2'b10, 15'h0100, 0), 4, 1, 6, "R9", -1, 0, 0);
    counts("R9");
    // R6 reserved target
    drive(2'b01, 1, mk(0, 3'd0, 2'b11, 15'h0200, 0), 4, -1, 7, "R6", -1, 0, 0);
    counts("R6");
    // R2 non-write opcode
    drive(2'b10, 0, mk(0, 3'd0, 2'b00, 15'h0300, 0), 2, -1, 8, "R2", -1, 0, 0);
    drive(2'b00, 1, mk(0, 3'd0, 2'b01, 15'h0301, 0), 4, -1, 9, "R2", -1, 0, 0);
    counts("R2");
    // R10 cmd_valid held through the burst
    drive(2'b01, 1, mk(0, 3'd0, 2'b00, 15'h0400, 0), 4, -1, 10, "R10", -1, 0, 1);
    counts("R10");
    chk(busy == 0, "R10", "idle after burst", busy, 0);
    // R11 load same register in address cycle: old value used, then new
    drive(2'b01, 0, mk(1, 3'd2, 2'b00, 15'h0002, 0), 1, -1, 11, "R11", 2, 15'h5550, 0);
    drive(2'b01, 0, mk(1, 3'd2, 2'b01, 15'h0001, 0), 1, -1, 12, "R11", -1, 0, 0);
    counts("R11");
    chk(q_addr.size() == 0, "R7", "scoreboard drained", q_addr.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule